// File: doc/BRIEF.md
# Programmable Scaled Tick Divider

This block turns a stream of single-cycle enable ticks into a slower stream of single-cycle enable ticks. The output rate is the input tick rate divided by twice an 8-bit scale value held in a small register. The block first counts the scale value down. It then halves the resulting rate with a toggle stage, so the output arrives on every second pass of the counter. A scale value of zero stands for 256, which gives division by 512.

The scale register can be written and read in any cycle. Every write restarts the division from the beginning, even a write of the value already held. The next output tick after a write therefore comes exactly twice the new scale value in input ticks later.

All logic runs on one clock. The input and output ticks are clock enables, not data, so they carry no valid/ready handshake and no back-pressure. An input tick is never held or stalled; it is either counted or ignored, and the output pulse is never held.

Top module: `scaled_tick_div`

## Requirements
- R1: While reset is held and directly after it, `rd_data` reads 0x00 and `tick_out` is low.
- R2: A write with `wr_en` high sets `rd_data` to `wr_data` from the next cycle on, in any cycle and with no restriction.
- R3: For a scale value N from 1 to 255, `tick_out` pulses in the cycle after the input tick whose count, taken since the last write, is a multiple of 2×N. It pulses after no other input tick.
- R4: A scale value of 0x00 counts as 256. This includes the reset value, so with no write the first pulse follows input tick 512.
- R5: Every write restarts the counter and clears the divide-by-two stage, including a write of the value already held. The next pulse follows exactly 2×N input ticks after the write.
- R6: An input tick that arrives in the same cycle as a write is not counted.
- R7: `tick_out` is high for one cycle at a time. It is high only in the cycle after an input tick that was not also a write cycle.
- R8: No output pulse is produced while reset is held, whatever the input ticks do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_in | input | 1 | Input enable tick, one cycle per tick |
| wr_en | input | 1 | Write strobe for the scale register |
| wr_data | input | 8 | Scale value to write |
| rd_data | output | 8 | Current scale value |
| tick_out | output | 1 | Scaled enable tick, one cycle wide |

## Verification
A written value shows on `rd_data` one cycle after the write cycle. An output pulse is registered, so it appears in the cycle that follows the input tick that completes the 2×N count. The bench drives every input on the falling edge and samples the outputs on the next falling edge, so each tick's result is read exactly one register stage later. Idle cycles between ticks are also sampled, and any pulse seen in them counts as a stray, which catches pulses that come with no tick behind them.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int SCL_W = 8;
  typedef logic [SCL_W-1:0] scale_t;
endpackage

// File: rtl/scl_scale_reg.sv
module scl_scale_reg #(
  parameter int W = scl_pkg::SCL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] scale_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     scale_q <= '0;
    else if (wr_en) scale_q <= wr_data;
  end

  AST_WR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> scale_q == $past(wr_data)); // R2
endmodule

// File: rtl/scl_down_counter.sv
module scl_down_counter #(
  parameter int W = scl_pkg::SCL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  output logic         term
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt;

  // cnt holds remaining ticks minus one; a scale of 0 wraps to all ones (full scale)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '1;
    else if (load)       cnt <= load_val - ONE;
    else if (tick) begin
      if (cnt == '0)     cnt <= reload_val - ONE;
      else               cnt <= cnt - ONE;
    end
  end

  assign term = tick && !load && (cnt == '0);

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == W'($past(load_val) - ONE)); // R5
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> cnt == W'($past(reload_val) - ONE)); // R3
endmodule

// File: rtl/scl_half_stage.sv
module scl_half_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic pulse_q
);
  logic half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= step && half && !clr;
      if (clr)       half <= 1'b0;
      else if (step) half <= ~half;
    end
  end

  AST_HALF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !half); // R5
  AST_PULSE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> !half); // R3
endmodule

// File: rtl/scaled_tick_div.sv
module scaled_tick_div #(
  parameter int SCALE_W = scl_pkg::SCL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_in,
  input  logic               wr_en,
  input  logic [SCALE_W-1:0] wr_data,
  output logic [SCALE_W-1:0] rd_data,
  output logic               tick_out
);
  logic [SCALE_W-1:0] scale_q;
  logic               mid_pulse;

  scl_scale_reg #(.W(SCALE_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .scale_q(scale_q)
  );

  scl_down_counter #(.W(SCALE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_in), .load(wr_en),
    .load_val(wr_data), .reload_val(scale_q), .term(mid_pulse)
  );

  scl_half_stage u_half (
    .clk(clk), .rst_n(rst_n), .clr(wr_en), .step(mid_pulse), .pulse_q(tick_out)
  );

  assign rd_data = scale_q;

  AST_OUT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> ($past(tick_in) && !$past(wr_en))); // R7
  AST_OUT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |=> !tick_out); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !tick_out); // R8
endmodule

// File: tb/scaled_tick_div_test.sv
module scaled_tick_div_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // each entry: {scale value, idle cycles between ticks}
  localparam logic [15:0] VEC [NVEC] = '{
    {8'd1, 8'd0}, {8'd2, 8'd1}, {8'd3, 8'd0}, {8'd7, 8'd2},
    {8'd16, 8'd0}, {8'd255, 8'd0}, {8'd0, 8'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_in = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic tick_out;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scaled_tick_div uut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .tick_out(tick_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] v, input logic with_tick);
    wr_en = 1'b1; wr_data = v; tick_in = with_tick;
    @(negedge clk);
    wr_en = 1'b0; tick_in = 1'b0;
  endtask

  task automatic tick_run(input int n, input int gap, output int cnt,
                          output int first, output int last_i, output int stray);
    cnt = 0; first = 0; last_i = 0; stray = 0;
    for (int i = 1; i <= n; i++) begin
      tick_in = 1'b1;
      @(negedge clk);
      tick_in = 1'b0;
      if (tick_out) begin
        cnt++;
        if (first == 0) first = i;
        last_i = i;
      end
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        if (tick_out) stray++;
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cnt, first, last_i, stray, m, bad;
    // R8: ticks during reset produce nothing
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      tick_in = 1'b1;
      @(negedge clk);
      if (tick_out) bad++;
    end
    tick_in = 1'b0;
    chk(bad == 0, "R8 pulses during reset", bad, 0);
    chk(rd_data == 8'h00, "R1 reset scale", rd_data, 0);
    chk(tick_out == 1'b0, "R1 reset output", tick_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 8'h00 && !tick_out, "R1 after reset", rd_data, 0);

    // R4: reset value 0 means divide by 512
    tick_run(512, 0, cnt, first, last_i, stray);
    chk(cnt == 1 && first == 512, "R4 reset divide-by-512 first", first, 512);

    // table walk: R3 / R4 / R2 / R7
    for (int v = 0; v < NVEC; v++) begin
      do_write(VEC[v][15:8], 1'b0);
      chk(rd_data == VEC[v][15:8], "R2 readback", rd_data, VEC[v][15:8]);
      m = (VEC[v][15:8] == 8'd0) ? 256 : int'(VEC[v][15:8]);
      tick_run(4*m + 1, int'(VEC[v][7:0]), cnt, first, last_i, stray);
      chk(cnt == 2, "R3 pulse count", cnt, 2);
      chk(first == 2*m, "R3 first pulse tick", first, 2*m);
      chk(last_i == 4*m, "R3 second pulse tick", last_i, 4*m);
      chk(stray == 0, "R7 pulses in idle cycles", stray, 0);
    end

    // R5: same-value write restarts the counter
    do_write(8'd4, 1'b0);
    tick_run(5, 0, cnt, first, last_i, stray);
    do_write(8'd4, 1'b0);
    tick_run(8, 0, cnt, first, last_i, stray);
    chk(cnt == 1 && first == 8, "R5 counter restart", first, 8);

    // R5: write clears the divide-by-two stage
    do_write(8'd3, 1'b0);
    tick_run(3, 0, cnt, first, last_i, stray);
    do_write(8'd3, 1'b0);
    tick_run(6, 0, cnt, first, last_i, stray);
    chk(cnt == 1 && first == 6, "R5 half stage cleared", first, 6);

    // R6: tick coinciding with a write is not counted
    do_write(8'd2, 1'b1);
    chk(tick_out == 1'b0, "R6 no pulse on write cycle", tick_out, 0);
    tick_run(4, 0, cnt, first, last_i, stray);
    chk(cnt == 1 && first == 4, "R6 write-cycle tick ignored", first, 4);

    // R8 / R1: reset in mid-run
    do_write(8'd1, 1'b0);
    tick_run(1, 0, cnt, first, last_i, stray);
    rst_n = 1'b0;
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      tick_in = 1'b1;
      @(negedge clk);
      if (tick_out) bad++;
    end
    tick_in = 1'b0;
    chk(bad == 0, "R8 mid-run reset quiet", bad, 0);
    chk(rd_data == 8'h00, "R1 scale cleared by reset", rd_data, 0);
    do_reset();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule